// File: doc/BRIEF.md
# NVMe Queue Pair Engine

This block runs one submission/completion queue pair on the host side of an NVMe link. A local producer hands it commands through a valid/ready port. Each accepted command gets a free command identifier and is packed into a 64-byte submission entry. The entry is stored in an internal submission ring, and the tail pointer moves forward. The new tail is then written to the queue's submission doorbell over a register-write master port.

The controller side reads submission entries through a read port. It deposits 16-byte completion entries into an internal completion ring through a write port. The engine polls the head slot of the completion ring every cycle. It treats an entry as new when the entry's phase bit matches the phase it expects. For each new entry it:
- reports the command identifier and status,
- retires the identifier,
- records the submission-queue head the controller reported,
- advances its own head.

Once no further new entry is waiting, it writes the new head to the completion doorbell.

Doorbell addresses follow the usual stride-4 layout: the submission doorbell is at base + 8·queue id and the completion doorbell at base + 8·queue id + 4. With the defaults these are 0x1008 and 0x100C.

Top module: `nvme_qpair_engine`

## Requirements
- R1: After reset, reqReady is 1, dbValid is 0, cplValid is 0 and reqCid is 0. The expected completion phase is 1, and both rings' pointers are 0.
- R2: An accepted request is written into the submission slot at the current tail. Bit positions in the entry: opcode [7:0], flags [15:8], command identifier [31:16], namespace [63:32], starting block [383:320], block count [399:384]. All other bits are zero.
- R3: After a request is accepted, reqReady stays 0 until a doorbell write to the submission doorbell address has been accepted. That write carries the advanced tail modulo DEPTH.
- R4: The ring is full when (tail+1) mod DEPTH equals the last reported submission head. While it is full, reqReady is 0.
- R5: The identifier given to a request (shown on reqCid while reqReady is 1) is the lowest identifier that is not outstanding.
- R6: A completion slot is taken only when its phase bit (bit 112) equals the expected phase. The expected phase starts at 1 and inverts each time the head wraps to 0. Stale entries produce no output.
- R7: For each new completion, cplValid pulses for one cycle with cplCid = bits [111:96] and cplStatus = bits [127:113]. The identifier becomes free again.
- R8: A completion whose identifier is not outstanding sets cplError and retires nothing. The head still advances.
- R9: The submission head in bits [79:64] of each consumed completion becomes the head used by the full test, freeing submission slots.
- R10: After one or more completions, a single doorbell write to the completion doorbell address carries the new head. It is issued only once the head slot holds no further new entry.
- R11: While dbValid is 1 and dbReady is 0, dbValid, dbAddr and dbValue hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Producer has a command |
| reqReady | output | 1 | Engine accepts the command this cycle |
| reqOpcode | input | 8 | Command opcode |
| reqFlags | input | 8 | Command flags byte |
| reqNsid | input | 32 | Namespace identifier |
| reqSlba | input | 64 | Starting logical block |
| reqBlocks | input | 16 | Transfer length in blocks |
| reqCid | output | log2(CID_COUNT) | Identifier assigned to the offered command |
| dbValid | output | 1 | Doorbell register write pending |
| dbReady | input | 1 | Register port takes the write |
| dbAddr | output | 16 | Doorbell register address |
| dbValue | output | 16 | Pointer value written |
| ctlSqIdx | input | log2(DEPTH) | Controller read index into the submission ring |
| ctlSqEntry | output | 512 | Submission entry at ctlSqIdx |
| ctlCqWrEn | input | 1 | Controller writes a completion entry |
| ctlCqWrIdx | input | log2(DEPTH) | Completion slot written |
| ctlCqWrData | input | 128 | Completion entry contents |
| cplValid | output | 1 | Completion reported this cycle |
| cplCid | output | 16 | Completed command identifier |
| cplStatus | output | 15 | Completion status field |
| cplError | output | 1 | Identifier was not outstanding |

## Verification
The bench fills the submission ring to its full point. It then frees one slot through a reported head and makes the tail wrap. A design with an off-by-one full test would overwrite an unconsumed slot. A design that ignored the reported head would stay stalled.

Completion batches are written last-slot-first. This forces the engine to drain consecutive slots before it rings once. An engine that rang per entry, or rang with a new entry still waiting, logs extra or early doorbells.

After the head wraps, stale entries from the previous pass sit in the ring with the old phase bit. A wrong phase flip would report them as fresh completions.

Duplicate and never-issued identifiers check the error flag. A held-off doorbell port checks that the pending write stays stable.

// File: rtl/qp_pkg.sv
package qp_pkg;
  localparam int SQE_W = 512;
  localparam int CQE_W = 128;
  localparam int DB_W  = 16;

  // submission entry field positions (decoded by the controller)
  localparam int SQE_OPC_LO   = 0;
  localparam int SQE_FLAGS_LO = 8;
  localparam int SQE_CID_LO   = 16;
  localparam int SQE_NSID_LO  = 32;
  localparam int SQE_SLBA_LO  = 320;
  localparam int SQE_NLB_LO   = 384;

  // completion entry field positions (produced by the controller)
  localparam int CQE_SQHD_LO  = 64;
  localparam int CQE_CID_LO   = 96;
  localparam int CQE_PHASE    = 112;
  localparam int CQE_STAT_LO  = 113;

  typedef struct packed {
    logic takeReq;
    logic eatCpl;
    logic fireSqDb;
    logic fireCqDb;
  } qpStrobes_t;

  typedef struct packed {
    logic sqFull;
    logic cidAvail;
    logic cqNew;
  } qpFlags_t;
endpackage

// File: rtl/qp_ctrl.sv
module qp_ctrl
  import qp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       dbReady,
  output logic       dbValid,
  input  qpFlags_t   flags,
  output qpStrobes_t strobes
);
  logic sqOwed;   // a submission doorbell is still to be completed
  logic cqOwed;   // completions consumed since the last completion doorbell
  logic dbBusy;
  logic dbIsSq;
  logic dbDone;

  assign dbDone  = dbBusy && dbReady;
  assign dbValid = dbBusy;

  always_comb begin
    reqReady         = flags.cidAvail && !flags.sqFull && !sqOwed;
    strobes.takeReq  = reqValid && reqReady;
    strobes.eatCpl   = flags.cqNew;
    strobes.fireSqDb = !dbBusy && sqOwed;
    strobes.fireCqDb = !dbBusy && !sqOwed && cqOwed && !flags.cqNew;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sqOwed <= 1'b0;
      cqOwed <= 1'b0;
      dbBusy <= 1'b0;
      dbIsSq <= 1'b0;
    end else begin
      if (strobes.takeReq)          sqOwed <= 1'b1;
      else if (dbDone && dbIsSq)    sqOwed <= 1'b0;

      if (strobes.eatCpl)           cqOwed <= 1'b1;
      else if (strobes.fireCqDb)    cqOwed <= 1'b0;

      if (strobes.fireSqDb || strobes.fireCqDb) begin
        dbBusy <= 1'b1;
        dbIsSq <= strobes.fireSqDb;
      end else if (dbDone) begin
        dbBusy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qp_datapath.sv
module qp_datapath
  import qp_pkg::*;
#(
  parameter int          DEPTH      = 16,
  parameter int          CID_COUNT  = 16,
  parameter logic [15:0] SQ_DB_ADDR = 16'h1008,
  parameter logic [15:0] CQ_DB_ADDR = 16'h100C,
  localparam int         PTR_W      = $clog2(DEPTH),
  localparam int         CID_W      = $clog2(CID_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qpStrobes_t       strobes,
  output qpFlags_t         flags,
  input  logic [7:0]       reqOpcode,
  input  logic [7:0]       reqFlags,
  input  logic [31:0]      reqNsid,
  input  logic [63:0]      reqSlba,
  input  logic [15:0]      reqBlocks,
  output logic [CID_W-1:0] reqCid,
  input  logic [PTR_W-1:0] ctlSqIdx,
  output logic [SQE_W-1:0] ctlSqEntry,
  input  logic             ctlCqWrEn,
  input  logic [PTR_W-1:0] ctlCqWrIdx,
  input  logic [CQE_W-1:0] ctlCqWrData,
  output logic             cplValid,
  output logic [15:0]      cplCid,
  output logic [14:0]      cplStatus,
  output logic             cplError,
  output logic [15:0]      dbAddr,
  output logic [DB_W-1:0]  dbValue
);
  localparam logic [15:0]      CID_LIMIT = 16'(CID_COUNT);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [SQE_W-1:0] sqRam [DEPTH];
  logic [CQE_W-1:0] cqRam [DEPTH];

  logic [PTR_W-1:0]     sqTail, sqHeadSeen, cqHead;
  logic                 expPhase;
  logic [CID_COUNT-1:0] busyMap, busyNext;
  logic [CID_W-1:0]     freeIdx;
  logic [SQE_W-1:0]     newEntry;
  logic [15:0]          headCid;
  logic [14:0]          headStatus;
  logic [PTR_W-1:0]     headSqHd;
  logic                 headPhase;
  logic                 cidKnown;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  // lowest identifier not outstanding
  always_comb begin
    freeIdx = '0;
    for (int i = CID_COUNT - 1; i >= 0; i--)
      if (!busyMap[i]) freeIdx = CID_W'(i);
  end

  assign reqCid = freeIdx;

  always_comb begin
    newEntry = '0;
    newEntry[SQE_OPC_LO   +: 8]  = reqOpcode;
    newEntry[SQE_FLAGS_LO +: 8]  = reqFlags;
    newEntry[SQE_CID_LO   +: 16] = 16'(freeIdx);
    newEntry[SQE_NSID_LO  +: 32] = reqNsid;
    newEntry[SQE_SLBA_LO  +: 64] = reqSlba;
    newEntry[SQE_NLB_LO   +: 16] = reqBlocks;
  end

  always_ff @(posedge clk) begin
    if (strobes.takeReq) sqRam[sqTail] <= newEntry;
  end

  assign ctlSqEntry = sqRam[ctlSqIdx];

  // completion ring: cleared so no slot looks new before the controller writes it
  generate
    for (genvar s = 0; s < DEPTH; s++) begin : gCqSlot
      always_ff @(posedge clk) begin
        if (!rst_n)
          cqRam[s] <= '0;
        else if (ctlCqWrEn && ctlCqWrIdx == PTR_W'(s))
          cqRam[s] <= ctlCqWrData;
      end
    end
  endgenerate

  always_comb begin
    headCid    = cqRam[cqHead][CQE_CID_LO +: 16];
    headStatus = cqRam[cqHead][CQE_STAT_LO +: 15];
    headSqHd   = cqRam[cqHead][CQE_SQHD_LO +: PTR_W];
    headPhase  = cqRam[cqHead][CQE_PHASE];
    cidKnown   = (headCid < CID_LIMIT) && busyMap[headCid[CID_W-1:0]];
  end

  always_comb begin
    flags.sqFull   = (nextPtr(sqTail) == sqHeadSeen);
    flags.cidAvail = ~&busyMap;
    flags.cqNew    = (headPhase == expPhase);
  end

  always_comb begin
    busyNext = busyMap;
    if (strobes.eatCpl && cidKnown) busyNext[headCid[CID_W-1:0]] = 1'b0;
    if (strobes.takeReq)            busyNext[freeIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sqTail     <= '0;
      sqHeadSeen <= '0;
      cqHead     <= '0;
      expPhase   <= 1'b1;
      busyMap    <= '0;
      cplValid   <= 1'b0;
      cplCid     <= '0;
      cplStatus  <= '0;
      cplError   <= 1'b0;
      dbAddr     <= '0;
      dbValue    <= '0;
    end else begin
      busyMap  <= busyNext;
      cplValid <= strobes.eatCpl;
      if (strobes.takeReq) sqTail <= nextPtr(sqTail);
      if (strobes.eatCpl) begin
        cplCid     <= headCid;
        cplStatus  <= headStatus;
        cplError   <= !cidKnown;
        sqHeadSeen <= headSqHd;
        cqHead     <= nextPtr(cqHead);
        if (cqHead == LAST_SLOT) expPhase <= !expPhase;
      end
      if (strobes.fireSqDb) begin
        dbAddr  <= SQ_DB_ADDR;
        dbValue <= DB_W'(sqTail);
      end else if (strobes.fireCqDb) begin
        dbAddr  <= CQ_DB_ADDR;
        dbValue <= DB_W'(cqHead);
      end
    end
  end
endmodule

// File: rtl/nvme_qpair_engine.sv
module nvme_qpair_engine
  import qp_pkg::*;
#(
  parameter int          DEPTH     = 16,
  parameter int          CID_COUNT = 16,
  parameter int          QUEUE_ID  = 1,
  parameter logic [15:0] DB_BASE   = 16'h1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [7:0]                   reqOpcode,
  input  logic [7:0]                   reqFlags,
  input  logic [31:0]                  reqNsid,
  input  logic [63:0]                  reqSlba,
  input  logic [15:0]                  reqBlocks,
  output logic [$clog2(CID_COUNT)-1:0] reqCid,
  output logic                         dbValid,
  input  logic                         dbReady,
  output logic [15:0]                  dbAddr,
  output logic [15:0]                  dbValue,
  input  logic [$clog2(DEPTH)-1:0]     ctlSqIdx,
  output logic [511:0]                 ctlSqEntry,
  input  logic                         ctlCqWrEn,
  input  logic [$clog2(DEPTH)-1:0]     ctlCqWrIdx,
  input  logic [127:0]                 ctlCqWrData,
  output logic                         cplValid,
  output logic [15:0]                  cplCid,
  output logic [14:0]                  cplStatus,
  output logic                         cplError
);
  localparam logic [15:0] SQ_DB_ADDR = DB_BASE + 16'(8 * QUEUE_ID);
  localparam logic [15:0] CQ_DB_ADDR = DB_BASE + 16'(8 * QUEUE_ID + 4);

  qpStrobes_t qpStrobes;
  qpFlags_t   qpFlags;

  qp_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .dbReady  (dbReady),
    .dbValid  (dbValid),
    .flags    (qpFlags),
    .strobes  (qpStrobes)
  );

  qp_datapath #(
    .DEPTH      (DEPTH),
    .CID_COUNT  (CID_COUNT),
    .SQ_DB_ADDR (SQ_DB_ADDR),
    .CQ_DB_ADDR (CQ_DB_ADDR)
  ) uData (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (qpStrobes),
    .flags       (qpFlags),
    .reqOpcode   (reqOpcode),
    .reqFlags    (reqFlags),
    .reqNsid     (reqNsid),
    .reqSlba     (reqSlba),
    .reqBlocks   (reqBlocks),
    .reqCid      (reqCid),
    .ctlSqIdx    (ctlSqIdx),
    .ctlSqEntry  (ctlSqEntry),
    .ctlCqWrEn   (ctlCqWrEn),
    .ctlCqWrIdx  (ctlCqWrIdx),
    .ctlCqWrData (ctlCqWrData),
    .cplValid    (cplValid),
    .cplCid      (cplCid),
    .cplStatus   (cplStatus),
    .cplError    (cplError),
    .dbAddr      (dbAddr),
    .dbValue     (dbValue)
  );
endmodule

// File: rtl/qp_checker.sv
module qp_checker #(
  parameter int          DEPTH   = 16,
  parameter logic [15:0] SQ_ADDR = 16'h1008,
  parameter logic [15:0] CQ_ADDR = 16'h100C
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic        reqReady,
  input logic        dbValid,
  input logic        dbReady,
  input logic [15:0] dbAddr,
  input logic [15:0] dbValue,
  input logic        cplValid,
  input logic        cqNew
);
  assert_req_blocked_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_req_during_sq_db_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbValid && dbAddr == SQ_ADDR) |-> !reqReady);

  assert_db_addr_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbValid |-> ((dbAddr == SQ_ADDR || dbAddr == CQ_ADDR) && dbValue < 16'(DEPTH)));

  assert_db_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dbValid && !dbReady) |=> (dbValid && $stable(dbAddr) && $stable(dbValue)));

  assert_cq_db_after_drain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dbValid) && dbAddr == CQ_ADDR) |-> !$past(cqNew));

  assert_cpl_from_new_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cplValid |-> $past(cqNew));
endmodule

bind nvme_qpair_engine qp_checker #(
  .DEPTH   (DEPTH),
  .SQ_ADDR (SQ_DB_ADDR),
  .CQ_ADDR (CQ_DB_ADDR)
) uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .dbValid  (dbValid),
  .dbReady  (dbReady),
  .dbAddr   (dbAddr),
  .dbValue  (dbValue),
  .cplValid (cplValid),
  .cqNew    (qpFlags.cqNew)
);

// File: tb/tb_nvme_qpair_engine.sv
module tb_nvme_qpair_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam logic [15:0] SQ_DB = 16'h1008;
  localparam logic [15:0] CQ_DB = 16'h100C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reqValid = 1'b0, reqReady;
  logic [7:0] reqOpcode = '0, reqFlags = '0;
  logic [31:0] reqNsid = '0;
  logic [63:0] reqSlba = '0;
  logic [15:0] reqBlocks = '0;
  logic [3:0] reqCid;
  logic dbValid, dbReady = 1'b1;
  logic [15:0] dbAddr, dbValue;
  logic [3:0] ctlSqIdx = '0;
  logic [511:0] ctlSqEntry;
  logic ctlCqWrEn = 1'b0;
  logic [3:0] ctlCqWrIdx = '0;
  logic [127:0] ctlCqWrData = '0;
  logic cplValid, cplError;
  logic [15:0] cplCid;
  logic [14:0] cplStatus;

  always #(CLK_PERIOD/2) clk = ~clk;

  nvme_qpair_engine dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOpcode(reqOpcode), .reqFlags(reqFlags), .reqNsid(reqNsid),
    .reqSlba(reqSlba), .reqBlocks(reqBlocks), .reqCid(reqCid),
    .dbValid(dbValid), .dbReady(dbReady), .dbAddr(dbAddr), .dbValue(dbValue),
    .ctlSqIdx(ctlSqIdx), .ctlSqEntry(ctlSqEntry), .ctlCqWrEn(ctlCqWrEn),
    .ctlCqWrIdx(ctlCqWrIdx), .ctlCqWrData(ctlCqWrData), .cplValid(cplValid),
    .cplCid(cplCid), .cplStatus(cplStatus), .cplError(cplError)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  bit mBusy [16];
  int mTail = 0;

  // doorbell log, filled by the handshake monitor
  logic [15:0] logA [64];
  logic [15:0] logV [64];
  int logN = 0, logRd = 0;

  always @(negedge clk)
    if (rst_n && dbValid && dbReady && logN < 64) begin
      logA[logN] = dbAddr;
      logV[logN] = dbValue;
      logN++;
    end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowestFree();
    for (int i = 0; i < 16; i++) if (!mBusy[i]) return i;
    return -1;
  endfunction

  task automatic expectDb(input logic [15:0] addr, input logic [15:0] val, input string tag);
    int t = 0;
    while (logRd >= logN && t < 100) begin @(negedge clk); t++; end
    if (logRd >= logN) begin
      check(0, {tag, " doorbell missing"}, 0, 1);
    end else begin
      check(logA[logRd] == addr, {tag, " doorbell addr"}, logA[logRd], addr);
      check(logV[logRd] == val,  {tag, " doorbell value"}, logV[logRd], val);
      logRd++;
    end
  endtask

  task automatic submit(input logic [7:0] op, input logic [7:0] fl, input logic [31:0] ns,
                        input logic [63:0] lba, input logic [15:0] nb, input bit waitDb);
    int t = 0;
    int expCid = lowestFree();
    int slot = mTail;
    while (!reqReady && t < 100) begin @(negedge clk); t++; end
    check(reqReady, "R4 producer stalled unexpectedly", reqReady, 1);
    check(reqCid == 4'(expCid), "R5 lowest free identifier", reqCid, expCid);
    reqValid = 1; reqOpcode = op; reqFlags = fl; reqNsid = ns; reqSlba = lba; reqBlocks = nb;
    @(negedge clk);
    reqValid = 0;
    mBusy[expCid] = 1;
    mTail = (mTail + 1) % DEPTH;
    ctlSqIdx = 4'(slot);
    #1;
    check(ctlSqEntry[7:0] == op && ctlSqEntry[15:8] == fl && ctlSqEntry[31:16] == 16'(expCid) &&
          ctlSqEntry[63:32] == ns && ctlSqEntry[383:320] == lba && ctlSqEntry[399:384] == nb &&
          ctlSqEntry[319:64] == '0 && ctlSqEntry[511:400] == '0,
          "R2 submission entry layout", ctlSqEntry[63:0], {ns, 16'(expCid), fl, op});
    if (waitDb) expectDb(SQ_DB, 16'(mTail), "R3 submission");
  endtask

  task automatic cqPut(input int slot, input logic [15:0] cid, input logic [14:0] st,
                       input logic [15:0] sqhd, input bit ph);
    ctlCqWrEn = 1; ctlCqWrIdx = 4'(slot);
    ctlCqWrData = '0;
    ctlCqWrData[79:64] = sqhd;
    ctlCqWrData[111:96] = cid;
    ctlCqWrData[112] = ph;
    ctlCqWrData[127:113] = st;
    @(negedge clk);
    ctlCqWrEn = 0;
  endtask

  task automatic expectCpl(input logic [15:0] cid, input logic [14:0] st, input bit err, input string tag);
    int t = 0;
    while (!cplValid && t < 100) begin @(negedge clk); t++; end
    check(cplValid, {tag, " completion missing"}, cplValid, 1);
    check(cplCid == cid, {tag, " R7 completion id"}, cplCid, cid);
    check(cplStatus == st, {tag, " R7 completion status"}, cplStatus, st);
    check(cplError == err, {tag, " R8 error flag"}, cplError, err);
    if (!err && cid < 16) mBusy[cid] = 0;
    @(negedge clk);
  endtask

  task automatic expectQuiet(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cplValid) bad++;
    end
    check(bad == 0, {tag, " no completion expected"}, bad, 0);
    check(logN == logRd, {tag, " no doorbell expected"}, logN, logRd);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mBusy[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(reqReady == 1, "R1 reqReady after reset", reqReady, 1);
    check(dbValid == 0, "R1 dbValid after reset", dbValid, 0);
    check(cplValid == 0, "R1 cplValid after reset", cplValid, 0);
    check(reqCid == 0, "R1 reqCid after reset", reqCid, 0);

    // fill the ring: identifiers 0..14
    for (int i = 0; i < DEPTH - 1; i++)
      submit(8'h01 + 8'(i % 3), 8'(i * 5), 32'h10 + 32'(i), 64'hA000_0000_0000 + 64'(i * 4096),
             16'(i + 1), 1);
    repeat (3) @(negedge clk);
    check(reqReady == 0, "R4 full ring blocks producer", reqReady, 0);

    // R9: one completion reports submission head 1
    cqPut(0, 16'd3, 15'h0, 16'd1, 1'b1);
    expectCpl(16'd3, 15'h0, 0, "single");
    expectDb(CQ_DB, 16'd1, "R10 single");
    @(negedge clk);
    check(reqReady == 1, "R9 reported head frees a slot", reqReady, 1);

    // reused identifier and tail wrap to 0, then full again
    submit(8'h02, 8'h40, 32'h77, 64'hFFFF_0000_1234_5678, 16'hFFFF, 1);
    repeat (3) @(negedge clk);
    check(reqReady == 0, "R4 full after tail wrap", reqReady, 0);

    // batch written last slot first
    cqPut(3, 16'd7, 15'h0004, 16'd4, 1'b1);
    cqPut(2, 16'd5, 15'h0002, 16'd3, 1'b1);
    cqPut(1, 16'd0, 15'h0000, 16'd2, 1'b1);
    expectCpl(16'd0, 15'h0000, 0, "batch a");
    expectCpl(16'd5, 15'h0002, 0, "batch b");
    expectCpl(16'd7, 15'h0004, 0, "batch c");
    expectDb(CQ_DB, 16'd4, "R10 batch");
    expectQuiet(10, "R10 one doorbell per batch");

    // R8: retired id 0 and never-issued id 15
    cqPut(5, 16'd15, 15'h7FFF, 16'd4, 1'b1);
    cqPut(4, 16'd0, 15'h0011, 16'd4, 1'b1);
    expectCpl(16'd0, 15'h0011, 1, "R8 retired id");
    expectCpl(16'd15, 15'h7FFF, 1, "R8 unknown id");
    expectDb(CQ_DB, 16'd6, "R8 head still advances");

    // drain to the ring end, head wraps
    begin
      logic [15:0] cids [10] = '{16'd1, 16'd2, 16'd4, 16'd6, 16'd8, 16'd9, 16'd10, 16'd11, 16'd12, 16'd13};
      for (int s = 15; s >= 6; s--) cqPut(s, cids[s - 6], 15'(s), 16'(s - 1), 1'b1);
      for (int s = 6; s <= 15; s++) expectCpl(cids[s - 6], 15'(s), 0, "wrap drain");
    end
    expectDb(CQ_DB, 16'd0, "R10 wrap");

    // R6: stale slot 0 (phase 1) must be ignored after the wrap
    expectQuiet(20, "R6 stale entry");
    cqPut(0, 16'd14, 15'h0003, 16'd14, 1'b1);
    expectQuiet(10, "R6 old phase rewritten");
    cqPut(0, 16'd14, 15'h0005, 16'd14, 1'b0);
    expectCpl(16'd14, 15'h0005, 0, "R6 flipped phase");
    expectDb(CQ_DB, 16'd1, "R10 after phase flip");

    // R11: doorbell held while the port stalls
    dbReady = 0;
    submit(8'h09, 8'h01, 32'h5, 64'h42, 16'h8, 0);
    begin
      int t = 0;
      int bad = 0;
      logic [15:0] v;
      while (!dbValid && t < 50) begin @(negedge clk); t++; end
      v = dbValue;
      check(dbValid && dbAddr == SQ_DB && v == 16'(mTail), "R11 stalled doorbell", v, mTail);
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (!dbValid || dbValue != v || dbAddr != SQ_DB || reqReady) bad++;
      end
      check(bad == 0, "R11 doorbell stable and R3 producer held", bad, 0);
    end
    dbReady = 1;
    expectDb(SQ_DB, 16'(mTail), "R11 released");
    repeat (5) @(negedge clk);
    check(reqReady == 1, "R3 producer released after doorbell", reqReady, 1);
    check(logN == logRd, "R10 no stray doorbells", logN, logRd);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule